// File: doc/BRIEF.md
# Hashed MAC Forwarding Table with Overflow CAM

This block is the layer-2 address store of a switch. For every frame the parser hands it a destination address, a source address and the number of the port the frame came in on. The block answers whether the destination is known and, if it is, on which port. It then records the source address against the ingress port so that later frames can be forwarded to it.

Storage has two levels. The main level is a direct-mapped table in block RAM, indexed by the low `HASH_BITS` bits of the address. The second level is a small fully associative CAM held in flip-flops. It takes addresses whose home slot already belongs to another station. Each entry holds the whole 48-bit address, a port number and a valid bit.

Software-facing extras are limited to three things:
- a per-port learning disable,
- a capture register that keeps the last source address the table did not know,
- a pulse that reports a new address lost because the CAM was full.

A frame is accepted when `req_ready` is high. After reset the table clears itself one slot per cycle before it accepts the first frame.

Top module: `mac_table`

## Requirements
- R1: After reset `req_ready` stays low while every hash slot is cleared, one slot per cycle (2^HASH_BITS cycles). While this runs, `rsp_valid`, `cam_full` and `unk_valid` are 0. After it, every address misses.
- R2: A destination whose 48 bits exactly equal a valid entry in its hash slot gives `rsp_hit`=1 and that entry's port on `rsp_port`. `rsp_valid` pulses for one cycle, two clock edges after the edge that accepts the frame.
- R3: A destination that shares its hash slot with a stored address but differs in any upper bit, and is not in the CAM, gives `rsp_hit`=0.
- R4: When the hash slot holds another address, the destination is looked up in the CAM, and a CAM hit returns the port of the CAM entry.
- R5: A source address whose hash slot is empty is written into that slot with the ingress port.
- R6: A source address whose hash slot holds a different address is written into a free CAM entry. The slot occupant keeps its port.
- R7: A source address already stored in either structure has its port rewritten in place. No second copy is made, so a relearn never consumes a CAM entry.
- R8: A new source address that needs the CAM while all CAM entries are valid is not stored. `cam_full` pulses for one cycle, three edges after acceptance, and all existing entries keep their addresses and ports.
- R9: While `learn_dis[p]` is 1, frames from port p neither add nor update any entry.
- R10: A source address found in neither structure is captured. `unk_word0` gets bits 47:32, `unk_word1` bits 31:16, `unk_word2` bits 15:0, `unk_port` the ingress port, and `unk_valid` is set and stays set. This happens even when learning is disabled. A known source leaves the capture unchanged.
- R11: The destination lookup of a frame sees the table as it was before that frame's own learning. A frame whose destination equals its new source address misses, and the next frame to that address hits.
- R12: One frame is in flight at a time. `req_ready` is low for the two cycles after the accepting edge and high again after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame lookup request |
| req_ready | output | 1 | Block can accept a frame this cycle |
| req_dmac | input | 48 | Destination address |
| req_smac | input | 48 | Source address |
| req_port | input | PW | Ingress port number |
| learn_dis | input | NPORTS | One learning-disable bit per port |
| rsp_valid | output | 1 | Destination result valid (one cycle) |
| rsp_hit | output | 1 | Destination found |
| rsp_port | output | PW | Port of the found destination |
| cam_full | output | 1 | Pulse: new address dropped, CAM full |
| unk_valid | output | 1 | Capture holds an unknown source |
| unk_word0 | output | 16 | Captured address bits 47:32 |
| unk_word1 | output | 16 | Captured address bits 31:16 |
| unk_word2 | output | 16 | Captured address bits 15:0 |
| unk_port | output | PW | Ingress port of the captured address |

## Verification
The bench builds the table with 8 ports, `HASH_BITS`=4 and a two-entry CAM. With these values the reset sweep lasts only 16 cycles, and a handful of addresses sharing low nibble 1 collide in one slot. That is enough to fill the CAM and reach the full-drop case with a few frames. Relearning an address that already sits in the CAM just before the CAM fills shows whether a duplicate entry is created, because a duplicate would raise `cam_full` one frame too early.

// File: rtl/mactbl_pkg.sv
package mactbl_pkg;
  localparam int MAC_W = 48;
  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_DST, ST_SRC} tbl_state_e;
endpackage

// File: rtl/mactbl_ram.sv
module mactbl_ram #(
  parameter int AW = 10,
  parameter int DW = 54,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Single write port, registered read: maps to one block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mactbl_cam.sv
module mactbl_cam
  import mactbl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW = 5,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAC_W-1:0] key,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [MAC_W-1:0] wr_mac,
  input  logic [PW-1:0]    wr_port,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic [PW-1:0]    hit_port,
  output logic             has_free,
  output logic [IW-1:0]    free_idx
);
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] match;
  logic [MAC_W-1:0] mac_q  [DEPTH];
  logic [PW-1:0]    port_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign match[g] = vld[g] && (mac_q[g] == key);
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        vld[g]    <= 1'b1;
        mac_q[g]  <= wr_mac;
        port_q[g] <= wr_port;
      end
    end
  end

  // Lowest-index match and lowest-index free entry.
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
      if (!vld[i])  free_idx = IW'(i);
    end
  end

  assign hit      = |match;
  assign has_free = ~&vld;
  assign hit_port = port_q[hit_idx];

  // R7: relearning never leaves two CAM entries with the same address
  a_r7_cam_unique: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R8: a write only fills a free entry or rewrites the same address
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!vld[wr_idx] || (mac_q[wr_idx] == wr_mac)));
endmodule

// File: rtl/mac_table.sv
module mac_table
  import mactbl_pkg::*;
#(
  parameter int NPORTS    = 26,
  parameter int HASH_BITS = 10,
  parameter int CAM_DEPTH = 64,
  localparam int PW  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int CIW = (CAM_DEPTH > 1) ? $clog2(CAM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [47:0]       req_dmac,
  input  logic [47:0]       req_smac,
  input  logic [PW-1:0]     req_port,
  input  logic [NPORTS-1:0] learn_dis,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PW-1:0]     rsp_port,
  output logic              cam_full,
  output logic              unk_valid,
  output logic [15:0]       unk_word0,
  output logic [15:0]       unk_word1,
  output logic [15:0]       unk_word2,
  output logic [PW-1:0]     unk_port
);
  localparam int EW   = 1 + PW + MAC_W;
  localparam int DISW = 1 << PW;

  tbl_state_e           st;
  logic [HASH_BITS-1:0] init_idx;
  logic [MAC_W-1:0]     dmac_q, smac_q;
  logic [PW-1:0]        port_q;

  // hash RAM
  logic                 ram_we;
  logic [HASH_BITS-1:0] ram_waddr, ram_raddr;
  logic [EW-1:0]        ram_wdata, rd_q;
  logic                 rd_vld;
  logic [PW-1:0]        rd_port;
  logic [MAC_W-1:0]     rd_mac;

  // CAM
  logic [MAC_W-1:0] cam_key;
  logic             cam_we, cam_hit, cam_free;
  logic [CIW-1:0]   cam_widx, cam_hidx, cam_fidx;
  logic [PW-1:0]    cam_hport;

  logic [DISW-1:0] dis_ext;
  logic            slot_match, learn_ok, unknown, full_ev;

  assign ram_raddr = (st == ST_IDLE) ? req_dmac[HASH_BITS-1:0] : smac_q[HASH_BITS-1:0];
  assign {rd_vld, rd_port, rd_mac} = rd_q;

  mactbl_ram #(.AW(HASH_BITS), .DW(EW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (rd_q)
  );

  assign cam_key = (st == ST_DST) ? dmac_q : smac_q;

  mactbl_cam #(.DEPTH(CAM_DEPTH), .PW(PW)) u_cam (
    .clk      (clk),
    .rst      (rst),
    .key      (cam_key),
    .wr_en    (cam_we),
    .wr_idx   (cam_widx),
    .wr_mac   (smac_q),
    .wr_port  (port_q),
    .hit      (cam_hit),
    .hit_idx  (cam_hidx),
    .hit_port (cam_hport),
    .has_free (cam_free),
    .free_idx (cam_fidx)
  );

  assign dis_ext    = DISW'(learn_dis);
  assign learn_ok   = !dis_ext[port_q];
  assign slot_match = rd_vld && (rd_mac == cam_key);
  assign unknown    = !slot_match && !cam_hit;
  assign full_ev    = learn_ok && rd_vld && unknown && !cam_free;
  assign cam_widx   = cam_hit ? cam_hidx : cam_fidx;

  // Learning write decision (source phase) and clear sweep (init phase).
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = smac_q[HASH_BITS-1:0];
    ram_wdata = {1'b1, port_q, smac_q};
    cam_we    = 1'b0;
    if (st == ST_INIT) begin
      ram_we    = 1'b1;
      ram_waddr = init_idx;
      ram_wdata = '0;
    end else if (st == ST_SRC && learn_ok) begin
      ram_we = slot_match || !rd_vld;
      cam_we = rd_vld && !slot_match && (cam_hit || cam_free);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_INIT;
      init_idx  <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_port  <= '0;
      cam_full  <= 1'b0;
      unk_valid <= 1'b0;
      unk_word0 <= '0;
      unk_word1 <= '0;
      unk_word2 <= '0;
      unk_port  <= '0;
      dmac_q    <= '0;
      smac_q    <= '0;
      port_q    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      cam_full  <= 1'b0;
      case (st)
        ST_INIT: begin
          init_idx <= init_idx + 1'b1;
          if (&init_idx) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            dmac_q <= req_dmac;
            smac_q <= req_smac;
            port_q <= req_port;
            st     <= ST_DST;
          end
        end
        ST_DST: begin
          rsp_valid <= 1'b1;
          rsp_hit   <= slot_match || cam_hit;
          rsp_port  <= slot_match ? rd_port : (cam_hit ? cam_hport : '0);
          st        <= ST_SRC;
        end
        default: begin
          cam_full <= full_ev;
          if (unknown) begin
            unk_valid <= 1'b1;
            unk_word0 <= smac_q[47:32];
            unk_word1 <= smac_q[31:16];
            unk_word2 <= smac_q[15:0];
            unk_port  <= port_q;
          end
          st <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);

  // R11: learning writes only after the destination result is out
  a_r11_search_first: assert property (@(posedge clk) disable iff (rst)
    (cam_we || (ram_we && st != ST_INIT)) |-> rsp_valid);

  // R12: no new frame is accepted while a result is pending
  a_r12_busy: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R10: the capture valid flag is sticky
  a_r10_unk_sticky: assert property (@(posedge clk) disable iff (rst)
    unk_valid |=> unk_valid);

  // R8: the full pulse lasts one cycle
  a_r8_full_pulse: assert property (@(posedge clk) disable iff (rst)
    cam_full |=> !cam_full);
endmodule

// File: tb/sim_mac_table.sv
module sim_mac_table;
  localparam int NP = 8;
  localparam int HB = 4;
  localparam int CD = 2;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [47:0]   req_dmac = '0, req_smac = '0;
  logic [PW-1:0] req_port = '0;
  logic [NP-1:0] learn_dis = '0;
  logic          rsp_valid, rsp_hit, cam_full, unk_valid;
  logic [PW-1:0] rsp_port, unk_port;
  logic [15:0]   unk_word0, unk_word1, unk_word2;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic          s_hit, s_full;
  logic [PW-1:0] s_port;

  always #2.5 clk = ~clk;

  mac_table #(.NPORTS(NP), .HASH_BITS(HB), .CAM_DEPTH(CD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_dmac(req_dmac), .req_smac(req_smac), .req_port(req_port),
    .learn_dis(learn_dis), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_port(rsp_port), .cam_full(cam_full), .unk_valid(unk_valid),
    .unk_word0(unk_word0), .unk_word1(unk_word1), .unk_word2(unk_word2),
    .unk_port(unk_port)
  );

  // Addresses: A, B, C, D share hash slot 1; Z slot 15; E slot 6; F slot 9
  localparam logic [47:0] MA = 48'h0000_1111_0001;
  localparam logic [47:0] MB = 48'h0000_2222_0001;
  localparam logic [47:0] MC = 48'h0000_3333_0001;
  localparam logic [47:0] MD = 48'h0000_4444_0001;
  localparam logic [47:0] ME = 48'h0000_5555_0006;
  localparam logic [47:0] MF = 48'h0000_6666_0009;
  localparam logic [47:0] MZ = 48'h00AA_0000_000F;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends one frame; samples result after edge 2 and full pulse after edge 3.
  task automatic frame(input logic [47:0] d, input logic [47:0] s, input logic [PW-1:0] p);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_dmac = d; req_smac = s; req_port = p;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy after accept", req_ready, 0);
    @(negedge clk);
    chk("R2 rsp_valid timing", rsp_valid, 1);
    s_hit = rsp_hit; s_port = rsp_port;
    @(negedge clk);
    chk("R2 rsp_valid one cycle", rsp_valid, 0);
    chk("R12 ready again", req_ready, 1);
    s_full = cam_full;
  endtask

  task automatic look(input logic [47:0] d, input string req, input logic hit, input logic [PW-1:0] p);
    frame(d, MZ, 3'd0);
    chk({req, " hit"}, s_hit, hit);
    if (hit) chk({req, " port"}, s_port, p);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 ready low during clear", req_ready, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cam_full", cam_full, 0);
    chk("R1 unk_valid", unk_valid, 0);
    repeat (20) @(negedge clk);
    chk("R1 ready after clear", req_ready, 1);
    frame(MA, MZ, 3'd0);
    chk("R1 empty table miss", s_hit, 0);
    chk("R10 capture valid", unk_valid, 1);
    chk("R10 capture words", {unk_word0, unk_word1, unk_word2}, MZ);
    chk("R10 capture port", unk_port, 0);
  endtask

  task automatic t_slot;
    frame(MZ, MA, 3'd3);
    chk("R10 capture A", {unk_word0, unk_word1, unk_word2}, MA);
    chk("R10 capture A port", unk_port, 3);
    look(MA, "R5 R2 slot learn", 1, 3);
    look(MB, "R3 exact match", 0, 0);
  endtask

  task automatic t_cam;
    frame(MZ, MB, 3'd4);
    chk("R6 no full", s_full, 0);
    look(MB, "R4 R6 cam hit", 1, 4);
    look(MA, "R6 slot kept", 1, 3);
  endtask

  task automatic t_update;
    frame(MZ, MA, 3'd6);
    look(MA, "R7 slot update", 1, 6);
    frame(MZ, MB, 3'd1);
    chk("R7 no dup", s_full, 0);
    chk("R10 known keeps capture", {unk_word0, unk_word1, unk_word2}, MB);
    chk("R10 known keeps port", unk_port, 4);
    look(MB, "R7 cam update", 1, 1);
    frame(MZ, MC, 3'd5);
    chk("R7 cam not consumed", s_full, 0);
    look(MC, "R6 second cam", 1, 5);
  endtask

  task automatic t_full;
    frame(MZ, MD, 3'd2);
    chk("R8 full pulse", s_full, 1);
    @(negedge clk);
    chk("R8 pulse ends", cam_full, 0);
    chk("R10 capture D", {unk_word0, unk_word1, unk_word2}, MD);
    look(MD, "R8 not learned", 0, 0);
    look(MB, "R8 B intact", 1, 1);
    look(MC, "R8 C intact", 1, 5);
    look(MA, "R8 A intact", 1, 6);
  endtask

  task automatic t_dis;
    learn_dis = 8'h80;
    frame(MZ, ME, 3'd7);
    chk("R10 capture while disabled", unk_port, 7);
    look(ME, "R9 no insert", 0, 0);
    frame(MZ, MA, 3'd7);
    look(MA, "R9 no update", 1, 6);
    frame(MZ, MB, 3'd7);
    look(MB, "R9 no cam update", 1, 1);
    learn_dis = 8'h00;
    frame(MZ, ME, 3'd7);
    look(ME, "R9 enabled again", 1, 7);
  endtask

  task automatic t_same;
    frame(MF, MF, 3'd2);
    chk("R11 own source not seen", s_hit, 0);
    look(MF, "R11 next frame", 1, 2);
  endtask

  initial begin
    t_reset();
    t_slot();
    t_cam();
    t_update();
    t_full();
    t_dis();
    t_same();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule